// File: doc/BRIEF.md
# Parallel Display Bus Strobe Sequencer

This block drives the chip-select, write-enable and read-enable lines of an 8080-style parallel display bus for one access at a time. A requester raises a request with a direction bit. The sequencer then counts timing ticks from the start of the access and opens and closes each strobe at its own programmed tick. A write or a read also has its own total cycle length. For reads, the block emits a one-clock capture pulse at the programmed access time, so that a neighbouring data path can register the bus.

All timing comes from two configuration words, which are copied when an access is accepted. Ticks come from a tick-enable input. A coarse-granularity input makes each timing tick last two tick enables. Settings that break the ordering rules are repaired at run time rather than rejected, so the strobe sequence always stays well formed. The active level of each strobe can be inverted at the pin.

Top module: `pss_strobe_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, every strobe sits at its inactive level (high when its invert bit is 0), `req_ready` is 1, and `rd_capture` and `done` are 0.
- R2: `timing_a` holds, for CS, WE and RE in that order, a 4-bit on tick and then a 6-bit off tick (CS on [3:0], CS off [9:4], WE on [13:10], WE off [19:14], RE on [23:20], RE off [29:24]). `timing_b` holds the write cycle at [5:0], the read cycle at [11:6], the CS minimum width at [17:12] and the read access time at [27:22]. Both words are sampled only in the clock where a request is accepted.
- R3: Let t be the number of ticks since acceptance. CS is active while on <= t < effective off, for writes and for reads.
- R4: WE follows its window only in write accesses and RE only in read accesses. Otherwise each stays inactive.
- R5: The effective WE and RE off ticks are max(off, on+1). The effective CS off tick is the largest of CS off, CS on+1, CS on + minimum width, and both effective WE and RE off ticks.
- R6: The effective access time is max(access, RE on+1). The effective write cycle is max(write cycle, effective CS off). The effective read cycle is max(read cycle, effective CS off, effective access time + 1).
- R7: In a read, `rd_capture` is high for exactly the one clock in which t first equals the effective access time. It is never high in writes.
- R8: An access ends at the tick that makes t equal to its effective cycle. `req_ready` is 0 from the clock after acceptance until then, and `done` is high for the single clock after the ending edge.
- R9: A request is accepted only at a clock edge where `req_ready` is 1. A request held high through a busy access is accepted one clock after the previous access ends, so back-to-back accesses start effective cycle + 1 clocks apart.
- R10: With `coarse_tick` 0, each clock with `tick_en` high is one tick. With it 1, ticks fall on every second `tick_en` counted from acceptance. With `tick_en` low, no timing progress is made.
- R11: `strobe_invert` bit 0, 1 and 2 swap the pin levels of CS, WE and RE respectively, in idle and during accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timing tick enable |
| coarse_tick | input | 1 | One tick per two enables when 1 |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ready | output | 1 | Sequencer can accept a request |
| timing_a | input | 30 | Strobe on/off ticks |
| timing_b | input | 28 | Cycle lengths, CS minimum width, access time |
| strobe_invert | input | 3 | Per-strobe level inversion (CS, WE, RE) |
| cs_n | output | 1 | Chip-select strobe |
| we_n | output | 1 | Write-enable strobe |
| re_n | output | 1 | Read-enable strobe |
| rd_capture | output | 1 | One-clock read data capture pulse |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
The end of one access and the acceptance of the next land in the same clock whenever a request is held high through a busy access. In that clock `done` is high, `req_ready` is high, and the new access is taken at the closing edge. The bench provokes this with a held request and with random request timing. A per-clock reference model judges it by predicting `done`, `req_ready` and the strobe levels in every clock, and a directed check confirms that the spacing between accepts is the effective cycle plus one clock. A second coincidence comes from the coarse tick: its phase restarts on the same edge that accepts a request while `tick_en` is high. The model, and a check on the doubled access length, pin that edge down.

// File: rtl/pss_pkg.sv
package pss_pkg;
   localparam int STB_N  = 3;
   localparam int STB_CS = 0;
   localparam int STB_WE = 1;
   localparam int STB_RE = 2;

   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } dir_e;
endpackage

// File: rtl/pss_tick_gen.sv
module pss_tick_gen #(
   parameter int COARSE_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic coarse,
   input  logic restart,
   output logic tick
);
   localparam int PH_W = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1;

   if (COARSE_DIV < 1) begin : g_bad_div
      $error("COARSE_DIV must be at least 1");
   end

   if (COARSE_DIV == 1) begin : g_flat
      logic [2:0] ignore_unused;
      assign ignore_unused = {clk, rst_n, coarse ^ restart};
      assign tick = tick_en;
   end else begin : g_div
      logic [PH_W-1:0] phase_q;
      logic            last_ph;

      assign last_ph = (phase_q == PH_W'(COARSE_DIV - 1));
      assign tick    = tick_en & (~coarse | last_ph);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (restart) begin
            phase_q <= '0;
         end else if (tick_en && coarse) begin
            phase_q <= last_ph ? '0 : phase_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pss_timing_clamp.sv
module pss_timing_clamp import pss_pkg::*; #(
   parameter int ON_W    = 4,
   parameter int OFF_W   = 6,
   parameter int ACT_LSB = 22,
   parameter int CNT_W   = 8,
   localparam int WA_W   = STB_N * (ON_W + OFF_W),
   localparam int WB_W   = ACT_LSB + OFF_W
) (
   input  logic [WA_W-1:0]  word_a,
   input  logic [WB_W-1:0]  word_b,
   output logic [CNT_W-1:0] on_e  [STB_N],
   output logic [CNT_W-1:0] off_e [STB_N],
   output logic [CNT_W-1:0] wcyc_e,
   output logic [CNT_W-1:0] rcyc_e,
   output logic [CNT_W-1:0] act_e
);
   localparam int PAIR_W = ON_W + OFF_W;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   function automatic logic [CNT_W-1:0] mx(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b);
      return (a > b) ? a : b;
   endfunction

   logic [CNT_W-1:0] on_r  [STB_N];
   logic [CNT_W-1:0] off_r [STB_N];
   logic [CNT_W-1:0] wcyc_r, rcyc_r, width_r, act_r;
   logic [CNT_W-1:0] cs_off_e;

   for (genvar s = 0; s < STB_N; s++) begin : g_fields
      assign on_r[s]  = {{(CNT_W-ON_W){1'b0}},  word_a[s*PAIR_W +: ON_W]};
      assign off_r[s] = {{(CNT_W-OFF_W){1'b0}}, word_a[s*PAIR_W+ON_W +: OFF_W]};
      assign on_e[s]  = on_r[s];
      if (s == STB_CS) begin : g_cs
         assign off_e[s] = cs_off_e;
      end else begin : g_data
         assign off_e[s] = mx(off_r[s], on_r[s] + ONE);
      end
   end

   assign wcyc_r  = {{(CNT_W-OFF_W){1'b0}}, word_b[0 +: OFF_W]};
   assign rcyc_r  = {{(CNT_W-OFF_W){1'b0}}, word_b[OFF_W +: OFF_W]};
   assign width_r = {{(CNT_W-OFF_W){1'b0}}, word_b[2*OFF_W +: OFF_W]};
   assign act_r   = {{(CNT_W-OFF_W){1'b0}}, word_b[ACT_LSB +: OFF_W]};

   if (ACT_LSB > 3*OFF_W) begin : g_gap
      logic gap_unused;
      assign gap_unused = ^word_b[ACT_LSB-1:3*OFF_W];
   end

   assign cs_off_e = mx(mx(mx(off_r[STB_CS], on_r[STB_CS] + ONE),
                           on_r[STB_CS] + width_r),
                        mx(off_e[STB_WE], off_e[STB_RE]));
   assign act_e  = mx(act_r, on_r[STB_RE] + ONE);
   assign wcyc_e = mx(wcyc_r, cs_off_e);
   assign rcyc_e = mx(mx(rcyc_r, cs_off_e), act_e + ONE);
endmodule

// File: rtl/pss_window.sv
module pss_window #(
   parameter int CNT_W = 8
) (
   input  logic             busy,
   input  logic             enable,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] t_on,
   input  logic [CNT_W-1:0] t_off,
   output logic             active
);
   logic opened, not_closed;

   assign opened     = (count >= t_on);
   assign not_closed = (count < t_off);
   assign active     = busy & enable & opened & not_closed;
endmodule

// File: rtl/pss_strobe_seq.sv
module pss_strobe_seq import pss_pkg::*; #(
   parameter int ON_W       = 4,
   parameter int OFF_W      = 6,
   parameter int ACT_LSB    = 22,
   parameter int COARSE_DIV = 2,
   localparam int WA_W      = STB_N * (ON_W + OFF_W),
   localparam int WB_W      = ACT_LSB + OFF_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   input  logic            coarse_tick,
   input  logic            req_valid,
   input  logic            req_write,
   output logic            req_ready,
   input  logic [WA_W-1:0] timing_a,
   input  logic [WB_W-1:0] timing_b,
   input  logic [2:0]      strobe_invert,
   output logic            cs_n,
   output logic            we_n,
   output logic            re_n,
   output logic            rd_capture,
   output logic            done
);
   localparam int CNT_W = ((ON_W > OFF_W) ? ON_W : OFF_W) + 2;

   if (ON_W < 1 || OFF_W < 2) begin : g_bad_width
      $error("timing field widths too small");
   end
   if (ON_W > OFF_W) begin : g_bad_order
      $error("on fields may not be wider than off fields");
   end
   if (ACT_LSB < 3*OFF_W) begin : g_bad_lsb
      $error("access time field overlaps cycle fields");
   end

   logic             accept, tick, busy_q, cap_q, done_q;
   dir_e             dir_q;
   logic [CNT_W-1:0] cnt_q, cnt_nxt, cyc_q, act_q;
   logic [CNT_W-1:0] on_c  [STB_N];
   logic [CNT_W-1:0] off_c [STB_N];
   logic [CNT_W-1:0] on_q  [STB_N];
   logic [CNT_W-1:0] off_q [STB_N];
   logic [CNT_W-1:0] wcyc_c, rcyc_c, act_c;
   logic [STB_N-1:0] stb_en, stb_act, stb_lvl;

   assign accept    = req_valid & ~busy_q;
   assign req_ready = ~busy_q;
   assign cnt_nxt   = cnt_q + 1'b1;

   pss_tick_gen #(.COARSE_DIV(COARSE_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .coarse  (coarse_tick),
      .restart (accept),
      .tick    (tick)
   );

   pss_timing_clamp #(
      .ON_W(ON_W), .OFF_W(OFF_W), .ACT_LSB(ACT_LSB), .CNT_W(CNT_W)
   ) u_clamp (
      .word_a (timing_a),
      .word_b (timing_b),
      .on_e   (on_c),
      .off_e  (off_c),
      .wcyc_e (wcyc_c),
      .rcyc_e (rcyc_c),
      .act_e  (act_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dir_q  <= DIR_READ;
         cnt_q  <= '0;
         cyc_q  <= '0;
         act_q  <= '0;
         for (int s = 0; s < STB_N; s++) begin
            on_q[s]  <= '0;
            off_q[s] <= '0;
         end
      end else if (accept) begin
         busy_q <= 1'b1;
         dir_q  <= req_write ? DIR_WRITE : DIR_READ;
         cnt_q  <= '0;
         cyc_q  <= req_write ? wcyc_c : rcyc_c;
         act_q  <= act_c;
         on_q   <= on_c;
         off_q  <= off_c;
      end else if (busy_q && tick) begin
         if (cnt_nxt == cyc_q) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_nxt;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         cap_q  <= busy_q & tick & (dir_q == DIR_READ) & (cnt_nxt == act_q);
         done_q <= busy_q & tick & (cnt_nxt == cyc_q);
      end
   end

   for (genvar s = 0; s < STB_N; s++) begin : g_stb
      if (s == STB_CS) begin : g_en_cs
         assign stb_en[s] = 1'b1;
      end else if (s == STB_WE) begin : g_en_we
         assign stb_en[s] = (dir_q == DIR_WRITE);
      end else begin : g_en_re
         assign stb_en[s] = (dir_q == DIR_READ);
      end

      pss_window #(.CNT_W(CNT_W)) u_win (
         .busy   (busy_q),
         .enable (stb_en[s]),
         .count  (cnt_q),
         .t_on   (on_q[s]),
         .t_off  (off_q[s]),
         .active (stb_act[s])
      );

      assign stb_lvl[s] = ~stb_act[s] ^ strobe_invert[s];
   end

   assign cs_n       = stb_lvl[STB_CS];
   assign we_n       = stb_lvl[STB_WE];
   assign re_n       = stb_lvl[STB_RE];
   assign rd_capture = cap_q;
   assign done       = done_q;
endmodule

// File: rtl/pss_strobe_seq_chk.sv
module pss_strobe_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [2:0] strobe_invert,
   input logic       cs_n,
   input logic       we_n,
   input logic       re_n,
   input logic       rd_capture,
   input logic       done
);
   logic cs_on, we_on, re_on;

   assign cs_on = (cs_n == strobe_invert[0]);
   assign we_on = (we_n == strobe_invert[1]);
   assign re_on = (re_n == strobe_invert[2]);

   a_r1_idle_strobes_off: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!cs_on && !we_on && !re_on));

   a_r4_we_re_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_on && re_on));

   a_r7_capture_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_capture |=> !rd_capture);

   a_r7_capture_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      rd_capture |-> (!req_ready && !we_on));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   a_r9_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

bind pss_strobe_seq pss_strobe_seq_chk u_chk (.*);

// File: tb/pss_strobe_seq_tb_top.sv
module pss_strobe_seq_tb_top;
   localparam int WA = 30;
   localparam int WB = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          coarse_tick = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [WA-1:0] timing_a = '0;
   logic [WB-1:0] timing_b = '0;
   logic [2:0]    strobe_invert = 3'b000;
   logic          req_ready, cs_n, we_n, re_n, rd_capture, done;

   int checks = 0;
   int errors = 0;
   int tick_mode = 0;
   int cyc_n = 0;

   always #4 clk = ~clk;

   pss_strobe_seq dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .coarse_tick(coarse_tick),
      .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
      .timing_a(timing_a), .timing_b(timing_b), .strobe_invert(strobe_invert),
      .cs_n(cs_n), .we_n(we_n), .re_n(re_n), .rd_capture(rd_capture), .done(done)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int mk_a(int cson, int csoff, int weon, int weoff, int reon, int reoff);
      return cson | (csoff << 4) | (weon << 10) | (weoff << 14) | (reon << 20) | (reoff << 24);
   endfunction

   function automatic int mk_b(int wcyc, int rcyc, int width, int acc);
      return wcyc | (rcyc << 6) | (width << 12) | (acc << 22);
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   // reference model state
   int m_busy = 0, m_cnt = 0, m_phase = 0, m_cap = 0, m_done = 0, m_wr = 0;
   int m_on[3], m_off[3];
   int m_cyc = 0, m_act = 0;

   task automatic m_load(input int a, input int b, input int wr);
      int wcyc, rcyc, width, acc, cso;
      m_on[0] = a & 15;         m_off[0] = (a >> 4) & 63;
      m_on[1] = (a >> 10) & 15; m_off[1] = (a >> 14) & 63;
      m_on[2] = (a >> 20) & 15; m_off[2] = (a >> 24) & 63;
      wcyc = b & 63; rcyc = (b >> 6) & 63; width = (b >> 12) & 63; acc = (b >> 22) & 63;
      m_off[1] = imax(m_off[1], m_on[1] + 1);
      m_off[2] = imax(m_off[2], m_on[2] + 1);
      cso = imax(imax(m_off[0], m_on[0] + 1), m_on[0] + width);
      m_off[0] = imax(cso, imax(m_off[1], m_off[2]));
      m_act = imax(acc, m_on[2] + 1);
      m_cyc = wr ? imax(wcyc, m_off[0]) : imax(imax(rcyc, m_off[0]), m_act + 1);
      m_wr = wr;
   endtask

   always @(posedge clk) begin
      cyc_n++;
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_phase = 0; m_cap = 0; m_done = 0;
      end else begin
         bit tk;
         tk = tick_en && (!coarse_tick || m_phase == 1);
         m_cap = 0; m_done = 0;
         if (req_valid && m_busy == 0) begin
            m_load(int'(timing_a), int'(timing_b), int'(req_write));
            m_busy = 1; m_cnt = 0; m_phase = 0;
         end else begin
            if (m_busy == 1 && tk) begin
               m_cnt++;
               if (m_wr == 0 && m_cnt == m_act) m_cap = 1;
               if (m_cnt == m_cyc) begin
                  m_busy = 0; m_cnt = 0; m_done = 1;
               end
            end
            if (tick_en && coarse_tick) m_phase = 1 - m_phase;
         end
      end
   end

   function automatic int win(int s);
      bit en;
      en = (s == 0) || (s == 1 && m_wr == 1) || (s == 2 && m_wr == 0);
      return (m_busy == 1 && en && m_cnt >= m_on[s] && m_cnt < m_off[s]) ? 1 : 0;
   endfunction

   // per-clock comparison with the model
   initial forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         check("R3 cs_n", int'(cs_n), (win(0) == 1) ? int'(strobe_invert[0]) : int'(!strobe_invert[0]));
         check("R4 we_n", int'(we_n), (win(1) == 1) ? int'(strobe_invert[1]) : int'(!strobe_invert[1]));
         check("R4 re_n", int'(re_n), (win(2) == 1) ? int'(strobe_invert[2]) : int'(!strobe_invert[2]));
         check("R7 rd_capture", int'(rd_capture), m_cap);
         check("R8 done", int'(done), m_done);
         check("R9 req_ready", int'(req_ready), 1 - m_busy);
      end
   end

   // tick enable driver
   initial forever begin
      @(negedge clk);
      case (tick_mode)
         0: tick_en = 1'b1;
         1: tick_en = ($urandom_range(0, 2) != 0);
         default: tick_en = 1'b0;
      endcase
   end

   task automatic run_access(input bit wr, input bit scramble,
                             output int n_cs, output int n_we, output int n_re,
                             output int n_busy, output int cap_idx, output int n_cap,
                             output int n_done);
      logic [WA-1:0] sa;
      logic [WB-1:0] sb;
      int idx;
      n_cs = 0; n_we = 0; n_re = 0; n_busy = 0; cap_idx = -1; n_cap = 0; n_done = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      sa = timing_a; sb = timing_b;
      if (scramble) begin timing_a = ~sa; timing_b = ~sb; end
      idx = 0;
      while (!req_ready) begin
         if (cs_n == strobe_invert[0]) n_cs++;
         if (we_n == strobe_invert[1]) n_we++;
         if (re_n == strobe_invert[2]) n_re++;
         if (rd_capture) begin n_cap++; cap_idx = idx; end
         idx++;
         @(negedge clk);
      end
      n_busy = idx;
      if (done) n_done = 1;
      timing_a = sa; timing_b = sb;
   endtask

   task automatic run_tests;
      int c, w, r, b, ci, nc, nd, t0, t1;
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      check("R1 cs_n reset", int'(cs_n), 1);
      check("R1 we_n reset", int'(we_n), 1);
      check("R1 re_n reset", int'(re_n), 1);
      check("R1 ready reset", int'(req_ready), 1);
      check("R1 capture reset", int'(rd_capture), 0);
      check("R1 done reset", int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // legal configuration, write, words changed during the access (R2)
      timing_a = WA'(mk_a(1, 6, 2, 5, 1, 4));
      timing_b = WB'(mk_b(8, 9, 2, 3));
      run_access(1'b1, 1'b1, c, w, r, b, ci, nc, nd);
      check("R3 cs ticks write", c, 5);
      check("R2 we ticks with words changed", w, 3);
      check("R4 re idle in write", r, 0);
      check("R8 write cycle", b, 8);
      check("R8 done pulse", nd, 1);
      check("R7 no capture in write", nc, 0);

      // legal read
      run_access(1'b0, 1'b0, c, w, r, b, ci, nc, nd);
      check("R3 cs ticks read", c, 5);
      check("R4 re ticks", r, 3);
      check("R4 we idle in read", w, 0);
      check("R6 read cycle", b, 9);
      check("R7 capture count", nc, 1);
      check("R7 capture position", ci, 3);

      // illegal configuration clamped
      timing_a = WA'(mk_a(0, 0, 4, 2, 3, 0));
      timing_b = WB'(mk_b(0, 0, 0, 0));
      run_access(1'b1, 1'b0, c, w, r, b, ci, nc, nd);
      check("R5 we off clamp", w, 1);
      check("R5 cs off raised to we off", c, 5);
      check("R6 write cycle raised", b, 5);
      run_access(1'b0, 1'b0, c, w, r, b, ci, nc, nd);
      check("R5 re off clamp", r, 1);
      check("R6 access time clamp", ci, 4);
      check("R6 read cycle raised", b, 5);

      // CS minimum width
      timing_a = WA'(mk_a(2, 3, 0, 1, 0, 1));
      timing_b = WB'(mk_b(1, 1, 6, 1));
      run_access(1'b1, 1'b0, c, w, r, b, ci, nc, nd);
      check("R5 cs min width", c, 6);
      check("R6 cycle follows cs", b, 8);

      // coarse granularity doubles
      timing_a = WA'(mk_a(1, 6, 2, 5, 1, 4));
      timing_b = WB'(mk_b(8, 9, 2, 3));
      coarse_tick = 1'b1;
      run_access(1'b1, 1'b0, c, w, r, b, ci, nc, nd);
      check("R10 coarse cycle", b, 16);
      check("R10 coarse cs", c, 10);
      check("R10 coarse we", w, 6);
      coarse_tick = 1'b0;

      // tick enable held low: no progress
      @(negedge clk);
      tick_mode = 2;
      req_valid = 1'b1; req_write = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      #1;
      check("R10 stalled busy", int'(req_ready), 0);
      check("R10 stalled cs inactive", int'(cs_n), 1);
      tick_mode = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);

      // polarity inversion
      strobe_invert = 3'b101;
      @(negedge clk);
      #1;
      check("R11 cs idle inverted", int'(cs_n), 0);
      check("R11 we idle plain", int'(we_n), 1);
      check("R11 re idle inverted", int'(re_n), 0);
      run_access(1'b1, 1'b0, c, w, r, b, ci, nc, nd);
      check("R11 cs ticks inverted", c, 5);
      check("R11 we ticks", w, 3);
      strobe_invert = 3'b000;

      // held request: back-to-back spacing, done coincides with accept
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1;
      @(negedge clk);
      while (req_ready) @(negedge clk);
      t0 = cyc_n;
      while (!req_ready) @(negedge clk);
      check("R8 done with ready", int'(done), 1);
      @(negedge clk);
      t1 = cyc_n;
      check("R9 back-to-back spacing", t1 - t0, 9);
      check("R9 re-accepted", int'(req_ready), 0);
      req_valid = 1'b0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);

      // random traffic judged by the model
      tick_mode = 1;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         timing_a = WA'($urandom);
         timing_b = WB'($urandom);
         coarse_tick = $urandom_range(0, 1) == 1;
         req_write = $urandom_range(0, 1) == 1;
         req_valid = 1'b1;
         repeat ($urandom_range(1, 4)) @(negedge clk);
         req_valid = 1'b0;
         while (!req_ready) @(negedge clk);
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule